// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Packet Fabric

This block links eight sources to eight sinks through three ranks of 2x2 switching cells. The wiring into each rank is a perfect shuffle, so a packet's path is fixed by its own destination tag and needs no central controller. Each input takes a packet made of a 3-bit destination tag and a payload under a valid/ready handshake. Each output presents delivered packets under the same handshake.

Every cell reads one tag bit. The first rank reads the most significant bit and the last rank reads the least significant bit. A bit of 0 sends the packet to the cell's upper output (even line) and a bit of 1 sends it to the lower output (odd line). Between ranks, line `a2 a1 a0` is rewired to line `a1 a0 a2`. The inputs also pass through this rewiring before the first rank. Each cell output holds a one-entry register. When two packets in one cell want the same output, a round-robin pointer grants one of them and the other waits. Stalls travel back to the sending input through the ready signals, and no packet is ever dropped.

Top module: `omega_net`

## Requirements
- R1: In the cycle after reset is released, every `out_valid` bit is low.
- R2: Every accepted packet leaves exactly once, on the output port whose index equals its 3-bit tag, with its tag and payload unchanged. Whenever `out_valid[j]` is high, `out_tag[j]` equals j.
- R3: A packet that meets no contention and no backpressure is visible on its output after the third rising edge, counting the edge that accepts it.
- R4: Inputs j and j+4 meet in the same first-rank cell. If both are valid with equal tag MSBs, exactly one is accepted in that cycle and the other sees `in_ready` low. This holds even when their full tags differ, and both packets are delivered later.
- R5: Each cell output grants with a pointer that starts at the upper input after reset and points to the other input after every grant. Two streams from inputs 0 and 4 to a common output therefore alternate, starting with input 0.
- R6: While `out_valid[j]` is high and `out_ready[j]` is low, the packet on port j stays unchanged. A blocked path holds exactly one packet per rank (three in all) and then keeps the feeding input's `in_ready` low. Nothing is lost when the port is released.
- R7: Packets from one input to one output arrive in their acceptance order. Every permutation traffic pattern (each input sending to a distinct output) is delivered in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Packet offered on each input |
| in_tag | input | 8x3 | Destination port index per input |
| in_data | input | 8x16 | Payload per input |
| in_ready | output | 8 | Packet on that input is taken at this edge |
| out_valid | output | 8 | Packet present on each output |
| out_tag | output | 8x3 | Tag of the presented packet |
| out_data | output | 8x16 | Payload of the presented packet |
| out_ready | input | 8 | Sink takes the presented packet |

## Verification
Arbitration between two inputs of one cell and backpressure from a later rank can land in the same cycle. When they do, a cell must refuse both inputs, or grant one input while holding its registered output. This is provoked by random traffic whose sink readiness is withheld at random while sources collide at random, and by a directed case that blocks one port while a single input keeps feeding it. The scoreboard then judges the result: each accepted packet must arrive exactly once, at its tagged port, in per-path order. A refused input must keep its packet until accepted, and a stalled output must hold its data.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // one-bit left rotation of a line number: the shuffle between ranks
  function automatic int unsigned shuffle_idx(int unsigned idx, int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 32'd1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction
endpackage

// File: rtl/omega_slot.sv
module omega_slot #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic         vld;
  logic [W-1:0] dat;

  assign in_ready  = !vld || out_ready;
  assign out_valid = vld;
  assign out_data  = dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (in_ready) begin
      vld <= in_valid;
      if (in_valid) dat <= in_data;
    end
  end

  // R1: reset leaves the slot empty
  a_r1_empty: assert property (@(posedge clk) rst |=> !out_valid);
  // R6: a stalled packet is held unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int STEER  = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    in_valid,
  input  logic [1:0][TAG_W+DATA_W-1:0]  in_pkt,
  output logic [1:0]                    in_ready,
  output logic [1:0]                    out_valid,
  output logic [1:0][TAG_W+DATA_W-1:0]  out_pkt,
  input  logic [1:0]                    out_ready
);
  localparam int PW = TAG_W + DATA_W;

  logic [1:0]      want;
  logic [1:0][1:0] req;
  logic [1:0][1:0] gv;
  logic [1:0]      both, sel, fire, sr, ptr;

  assign want[0] = in_pkt[0][DATA_W+STEER];
  assign want[1] = in_pkt[1][DATA_W+STEER];

  for (genvar o = 0; o < 2; o++) begin : g_out
    assign req[o][0] = in_valid[0] && (want[0] == 1'(o));
    assign req[o][1] = in_valid[1] && (want[1] == 1'(o));
    assign both[o]   = &req[o];
    assign sel[o]    = both[o] ? ptr[o] : req[o][1];
    assign fire[o]   = (|req[o]) && sr[o];
    assign gv[o]     = fire[o] ? (sel[o] ? 2'b10 : 2'b01) : 2'b00;

    omega_slot #(.W(PW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .in_valid (|req[o]),
      .in_data  (in_pkt[sel[o]]),
      .in_ready (sr[o]),
      .out_valid(out_valid[o]),
      .out_data (out_pkt[o]),
      .out_ready(out_ready[o])
    );

    always_ff @(posedge clk) begin
      if (rst)          ptr[o] <= 1'b0;
      else if (fire[o]) ptr[o] <= !sel[o];
    end

    // R4: contended output with room grants exactly one input
    a_r4_serial: assert property (@(posedge clk) disable iff (rst)
      (both[o] && sr[o]) |-> $onehot(gv[o]));
    // R5: after upper input wins a contest, the lower one wins the next
    a_r5_rr: assert property (@(posedge clk) disable iff (rst)
      (fire[o] && both[o] && !sel[o]) |=> (!(both[o] && sr[o]) || sel[o]));
  end

  assign in_ready = gv[0] | gv[1];

  // R2: an input is never taken by both outputs
  a_r2_once: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gv[0][0], gv[1][0]}) && $onehot0({gv[0][1], gv[1][1]}));
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  localparam int TAG_W  = $clog2(N_PORTS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_PORTS-1:0]              in_valid,
  input  logic [N_PORTS-1:0][TAG_W-1:0]   in_tag,
  input  logic [N_PORTS-1:0][DATA_W-1:0]  in_data,
  output logic [N_PORTS-1:0]              in_ready,
  output logic [N_PORTS-1:0]              out_valid,
  output logic [N_PORTS-1:0][TAG_W-1:0]   out_tag,
  output logic [N_PORTS-1:0][DATA_W-1:0]  out_data,
  input  logic [N_PORTS-1:0]              out_ready
);
  import omega_pkg::*;

  localparam int STAGES = TAG_W;
  localparam int PW     = TAG_W + DATA_W;
  localparam int CELLS  = N_PORTS / 2;

  // boundary b feeds rank b; boundary STAGES is the output side
  logic          lv [STAGES+1][N_PORTS];
  logic [PW-1:0] lp [STAGES+1][N_PORTS];
  logic          lr [STAGES+1][N_PORTS];
  logic          sv [STAGES][N_PORTS];
  logic [PW-1:0] sp [STAGES][N_PORTS];
  logic          srd[STAGES][N_PORTS];

  for (genvar j = 0; j < N_PORTS; j++) begin : g_edge
    assign lv[0][j]      = in_valid[j];
    assign lp[0][j]      = {in_tag[j], in_data[j]};
    assign in_ready[j]   = lr[0][j];
    assign out_valid[j]  = lv[STAGES][j];
    assign out_tag[j]    = lp[STAGES][j][PW-1:DATA_W];
    assign out_data[j]   = lp[STAGES][j][DATA_W-1:0];
    assign lr[STAGES][j] = out_ready[j];

    // R2: each port only ever presents its own tag
    a_r2_tag: assert property (@(posedge clk) disable iff (rst)
      out_valid[j] |-> (out_tag[j] == TAG_W'(j)));
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar j = 0; j < N_PORTS; j++) begin : g_shuf
      localparam int unsigned T = shuffle_idx(j, TAG_W);
      assign sv[s][T]  = lv[s][j];
      assign sp[s][T]  = lp[s][j];
      assign lr[s][j]  = srd[s][T];
    end
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
      logic [1:0]         iv, ir, ov, orr;
      logic [1:0][PW-1:0] ip, op;
      assign iv  = {sv[s][2*k+1], sv[s][2*k]};
      assign ip  = {sp[s][2*k+1], sp[s][2*k]};
      assign srd[s][2*k]   = ir[0];
      assign srd[s][2*k+1] = ir[1];
      assign lv[s+1][2*k]   = ov[0];
      assign lv[s+1][2*k+1] = ov[1];
      assign lp[s+1][2*k]   = op[0];
      assign lp[s+1][2*k+1] = op[1];
      assign orr = {lr[s+1][2*k+1], lr[s+1][2*k]};

      omega_switch #(.TAG_W(TAG_W), .DATA_W(DATA_W), .STEER(TAG_W-1-s)) u_sw (
        .clk      (clk),
        .rst      (rst),
        .in_valid (iv),
        .in_pkt   (ip),
        .in_ready (ir),
        .out_valid(ov),
        .out_pkt  (op),
        .out_ready(orr)
      );
    end
  end
endmodule

// File: tb/omega_net_tb.sv
`timescale 1ns/1ps
module omega_net_tb;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int SQ = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]         in_valid = '0;
  logic [N-1:0][2:0]    in_tag   = '0;
  logic [N-1:0][DW-1:0] in_data  = '0;
  logic [N-1:0]         in_ready;
  logic [N-1:0]         out_valid;
  logic [N-1:0][2:0]    out_tag;
  logic [N-1:0][DW-1:0] out_data;
  logic [N-1:0]         out_ready = '0;

  always #2.5 clk = ~clk;

  omega_net #(.N_PORTS(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data),
    .out_ready(out_ready)
  );

  int checks = 0, errors = 0, cyc = 0;
  int exp_dst [N][SQ];
  int acc_cyc [N][SQ];
  bit accd    [N][SQ];
  bit seen    [N][SQ];
  int last_sq [N][N];
  int seq_n[N], acc_n[N], rep[N], rep_dst[N], last_lat[N];
  bit pend[N], acc_last[N];
  int gen_pct = 0, rdy_pct = 100;
  int rdy_mode[N];  // 0 random, 1 high, 2 low
  int n_acc = 0, n_del = 0, log_port = -1;
  logic [DW-1:0] dlog[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int pick_dst();
    return int'($urandom % N);
  endfunction

  task automatic deliver(int j);
    logic [DW-1:0] p;
    int s, q;
    p = out_data[j];
    s = int'(p[15:13]);
    q = int'(p[9:0]);
    chk(out_tag[j] == 3'(j), "R2 tag", int'(out_tag[j]), j);
    chk(accd[s][q] && exp_dst[s][q] == j, "R2 port", j, exp_dst[s][q]);
    chk(!seen[s][q], "R2 once", 1, 0);
    seen[s][q] = 1'b1;
    last_lat[j] = cyc - acc_cyc[s][q];
    chk(last_lat[j] >= 3, "R3 min latency", last_lat[j], 3);
    chk(q > last_sq[s][j], "R7 order", q, last_sq[s][j] + 1);
    last_sq[s][j] = q;
    if (log_port == j) dlog.push_back(p);
    n_del++;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (acc_last[i]) pend[i] = 1'b0;
      if (!pend[i] && seq_n[i] < SQ) begin
        int d;
        d = -1;
        if (rep[i] > 0) begin d = rep_dst[i]; rep[i]--; end
        else if (int'($urandom % 100) < gen_pct) d = pick_dst();
        if (d >= 0) begin
          pend[i] = 1'b1;
          exp_dst[i][seq_n[i]] = d;
          in_tag[i]  = 3'(d);
          in_data[i] = {3'(i), 3'b000, 10'(seq_n[i])};
          seq_n[i]++;
        end
      end
      in_valid[i] = pend[i];
    end
    for (int j = 0; j < N; j++)
      out_ready[j] = (rdy_mode[j] == 1) || (rdy_mode[j] == 0 && int'($urandom % 100) < rdy_pct);
    #1;
    for (int j = 0; j < N; j++) if (out_valid[j] && out_ready[j]) deliver(j);
    for (int i = 0; i < N; i++) begin
      acc_last[i] = in_valid[i] && in_ready[i];
      if (acc_last[i]) begin
        int q;
        q = int'(in_data[i][9:0]);
        accd[i][q] = 1'b1;
        acc_cyc[i][q] = cyc;
        acc_n[i]++;
        n_acc++;
      end
    end
  endtask

  task automatic drain();
    gen_pct = 0;
    for (int j = 0; j < N; j++) rdy_mode[j] = 1;
    for (int k = 0; k < 400; k++) begin
      step();
      if (n_del == n_acc && rep.sum() == 0) begin
        bit idle;
        idle = 1'b1;
        for (int i = 0; i < N; i++) if (pend[i] && !acc_last[i]) idle = 1'b0;
        if (idle && out_valid == '0) break;
      end
    end
    chk(n_del == n_acc, "R2 all delivered", n_del, n_acc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, p0;
    logic [DW-1:0] held;
    void'($urandom(32'h5eed_0a11));
    for (int i = 0; i < N; i++) begin
      seq_n[i] = 0; acc_n[i] = 0; rep[i] = 0; pend[i] = 0; acc_last[i] = 0;
      rdy_mode[i] = 1;
      for (int j = 0; j < N; j++) last_sq[i][j] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R1 idle after reset", int'(out_valid), 0);

    // R3: lone packet input 2 -> port 5
    rep[2] = 1; rep_dst[2] = 5;
    base = n_del;
    repeat (6) step();
    chk(n_del == base + 1, "R3 delivered", n_del - base, 1);
    chk(last_lat[5] == 3, "R3 latency", last_lat[5], 3);

    // R4: inputs 0 and 4, tags 0 and 1 share MSB 0 -> collide in first rank
    rep[0] = 1; rep_dst[0] = 0; rep[4] = 1; rep_dst[4] = 1;
    step();
    chk(acc_last[0] && !acc_last[4], "R4 one granted", {acc_last[0], acc_last[4]}, 2);
    base = n_del;
    repeat (8) step();
    chk(n_del == base + 2, "R4 both delivered", n_del - base, 2);

    // R5: two streams 0 and 4 to port 2 alternate starting with input 0
    dlog.delete(); log_port = 2;
    rep[0] = 2; rep_dst[0] = 2; rep[4] = 2; rep_dst[4] = 2;
    repeat (12) step();
    chk(dlog.size() == 4, "R5 count", dlog.size(), 4);
    for (int k = 0; k < 4 && k < dlog.size(); k++)
      chk(int'(dlog[k][15:13]) == ((k % 2) ? 4 : 0), "R5 alternation", int'(dlog[k][15:13]), (k % 2) ? 4 : 0);

    // R6: port 3 blocked, input 1 feeds six packets
    dlog.delete(); log_port = 3;
    rdy_mode[3] = 2;
    p0 = acc_n[1];
    rep[1] = 6; rep_dst[1] = 3;
    repeat (10) step();
    held = out_data[3];
    chk(out_valid[3] == 1'b1, "R6 valid held", int'(out_valid[3]), 1);
    chk(acc_n[1] - p0 == 3, "R6 one per rank", acc_n[1] - p0, 3);
    chk(in_ready[1] == 1'b0, "R6 input stalled", int'(in_ready[1]), 0);
    repeat (3) step();
    chk(out_data[3] == held, "R6 data stable", int'(out_data[3]), int'(held));
    rdy_mode[3] = 1;
    repeat (12) step();
    chk(dlog.size() == 6, "R6 no loss", dlog.size(), 6);
    log_port = -1;

    // random traffic with random backpressure
    for (int j = 0; j < N; j++) rdy_mode[j] = 0;
    gen_pct = 60; rdy_pct = 70;
    repeat (800) step();
    drain();

    // R7: permutations, xor and bit-reverse patterns
    for (int m = 0; m < 5; m++) begin
      for (int i = 0; i < N; i++) begin
        rep[i] = 12;
        rep_dst[i] = (m < 4) ? (i ^ (m * 3 % 8)) : {i[0], i[1], i[2]};
      end
      base = n_del;
      drain();
      chk(n_del - base == 12 * N, "R7 permutation complete", n_del - base, 12 * N);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule